// File: doc/BRIEF.md
# eMMC PHY Power Sequencer

This block is a hardware state machine that brings a storage-interface PHY up or down, so no software driver has to do it. The chip asserts a one-cycle `req` with `req_power_on` set to 1 for a power-on or 0 for a power-off. It also presents the card clock rate in whole MHz. The block then drives the PHY control bits in a fixed order and watches two status bits, calibration-done and DLL-ready. It ends each sequence with a one-cycle `done` or `error` pulse. All waits are counted in cycles of the block's own clock. The parameter `CLK_MHZ` converts the microsecond limits into cycle counts.

States and transitions. The sequencer rests in `ST_IDLE`. An accepted request leaves it:

- A power-on goes to `ST_TXCLK`, then `ST_OTAP_EN`, then `ST_OTAP_SEL`, then `ST_PDB_LOW`.
- A power-off goes straight to `ST_PDB_LOW`.

From `ST_PDB_LOW` the sequence always goes to `ST_DLL_LOW`. From there:

- A power-off goes to `ST_DONE`.
- A power-on goes to `ST_SETTLE`. It stays there for the settle time, then goes to `ST_PDB_HIGH` and then `ST_CAL_WAIT`.

`ST_CAL_WAIT` goes to `ST_SET_FREQ` when calibration finishes, or to `ST_FAIL` on timeout. `ST_SET_FREQ` goes to `ST_DLL_ON`. `ST_DLL_ON` goes to `ST_DONE` if the latched rate is zero, and otherwise to `ST_LOCK_WAIT`. `ST_LOCK_WAIT` goes to `ST_DONE` on lock, or to `ST_FAIL` on timeout. `ST_DONE` and `ST_FAIL` both return to `ST_IDLE` after one cycle.

Top module: `emmc_phy_seq`

## Requirements
- R1: After reset, every control output, the frequency select, busy, done, error and the warning flag are 0.
- R2: Every request first drives `pwr_dn_b` low and then `dll_en` low, in that order. A power-off then ends with `done` and changes neither the tap-delay controls, the transmit-clock select nor the frequency select.
- R3: On a power-on, `txclk_dly_sel` goes to 1, then `otap_dly_en` goes to 1, then the 4-bit `otap_dly_sel` takes the value 2. Each change comes in a later cycle than the one before it, and all three come before `pwr_dn_b` rises.
- R4: The 3-bit `dll_freq_sel` comes from the latched rate in MHz. The bands are tested in this order, bounds inclusive, and the first match wins: 170..200 gives 0, 140..170 gives 1, 110..140 gives 2, 80..110 gives 3, 50..80 gives 4. Any other rate gives 0.
- R5: `rate_warn` is updated on each accepted request. It is 1 only for a power-on whose rate is above 175 MHz, and that sequence still completes.
- R6: `pwr_dn_b` rises no earlier than `SETTLE_US*CLK_MHZ` cycles after `dll_en` has fallen.
- R7: If calibration-done has not arrived within `CAL_TO_US*CLK_MHZ` cycles of `pwr_dn_b` rising, the sequence ends with `error` and `dll_en` stays 0.
- R8: `dll_en` rises only while `pwr_dn_b` is high, after calibration has finished. `dll_freq_sel` already holds its new value in the cycle `dll_en` rises.
- R9: With a latched rate of 0, `done` pulses no more than one cycle after `dll_en` rises, and DLL-ready is not waited for.
- R10: With a nonzero rate, the sequence waits for DLL-ready. It ends with `error` if lock has not come within `LOCK_TO_US*CLK_MHZ` cycles of `dll_en` rising.
- R11: Both status inputs pass through two-flop synchronizers. If calibration-done is high from the first edge after `pwr_dn_b` rises, `dll_en` rises at least 5 cycles after `pwr_dn_b`.
- R12: `busy` is 1 from the cycle after an accepted request until the cycle of `done` or `error`. `done` and `error` each last exactly one cycle and are never high together. A request that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle sequence request |
| req_power_on | input | 1 | 1 = power-on, 0 = power-off; sampled with `req` |
| rate_mhz | input | RATE_W | Card clock rate in whole MHz; sampled with `req` |
| cal_done_i | input | 1 | Calibration-done status from the PHY (asynchronous) |
| dll_rdy_i | input | 1 | DLL-ready status from the PHY (asynchronous) |
| txclk_dly_sel | output | 1 | Delay-chain transmit clock select |
| otap_dly_en | output | 1 | Output tap delay enable |
| otap_dly_sel | output | 4 | Output tap delay select |
| pwr_dn_b | output | 1 | Calibration power-down-bar |
| dll_en | output | 1 | DLL enable |
| dll_freq_sel | output | 3 | DLL frequency band |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle timeout pulse |
| rate_warn | output | 1 | Requested rate above 175 MHz |

## Verification
The hardest cases to reach from the ports are the two timeout exits and the rate-zero exit. They need a PHY model that withholds calibration-done or DLL-ready on command. The bench model raises each status bit a set number of cycles after the control bit it answers, or never. With it, the bench forces `ST_CAL_WAIT` and `ST_LOCK_WAIT` to expire and measures the expiry against the cycle in which `pwr_dn_b` or `dll_en` rose. A sweep runs a complete power-on for every rate from 0 to 260 MHz, which covers every band edge and the warning threshold. A further power-on injects an opposite request halfway through the sequence to show that it is dropped.

// File: rtl/emmc_seq_pkg.sv
package emmc_seq_pkg;

    localparam int OTAP_W = 4;
    localparam int FREQ_W = 3;
    localparam logic [OTAP_W-1:0] OTAP_SEL_VAL = 4'd2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TXCLK,
        ST_OTAP_EN,
        ST_OTAP_SEL,
        ST_PDB_LOW,
        ST_DLL_LOW,
        ST_SETTLE,
        ST_PDB_HIGH,
        ST_CAL_WAIT,
        ST_SET_FREQ,
        ST_DLL_ON,
        ST_LOCK_WAIT,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

endpackage

// File: rtl/emmc_sync2.sv
module emmc_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic [1:0] stage;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage <= 2'b00;
                else        stage <= {stage[0], async_i[g]};
            end
            assign sync_o[g] = stage[1];
        end
    endgenerate
endmodule

// File: rtl/emmc_rate_band.sv
module emmc_rate_band
    import emmc_seq_pkg::*;
#(
    parameter int RATE_W = 9
) (
    input  logic [RATE_W-1:0] rate_i,
    output logic [FREQ_W-1:0] band_o
);
    logic [31:0] r;

    always_comb begin
        r = 32'(rate_i);
        if      (r >= 32'd170 && r <= 32'd200) band_o = 3'd0;
        else if (r >= 32'd140 && r <= 32'd170) band_o = 3'd1;
        else if (r >= 32'd110 && r <= 32'd140) band_o = 3'd2;
        else if (r >= 32'd80  && r <= 32'd110) band_o = 3'd3;
        else if (r >= 32'd50  && r <= 32'd80)  band_o = 3'd4;
        else                                   band_o = 3'd0;
    end

    always_comb begin
        AST_BAND_RANGE: assert (band_o <= 3'd4); // R4
    end
endmodule

// File: rtl/emmc_wait_timer.sv
module emmc_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (clr)           cnt <= '0;
        else if (cnt != '1)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/emmc_phy_seq.sv
module emmc_phy_seq
    import emmc_seq_pkg::*;
#(
    parameter int CLK_MHZ    = 250,
    parameter int RATE_W     = 9,
    parameter int SETTLE_US  = 5,
    parameter int CAL_TO_US  = 50,
    parameter int LOCK_TO_US = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_power_on,
    input  logic [RATE_W-1:0] rate_mhz,
    input  logic              cal_done_i,
    input  logic              dll_rdy_i,
    output logic              txclk_dly_sel,
    output logic              otap_dly_en,
    output logic [OTAP_W-1:0] otap_dly_sel,
    output logic              pwr_dn_b,
    output logic              dll_en,
    output logic [FREQ_W-1:0] dll_freq_sel,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              rate_warn
);
    localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
    localparam int CAL_CYC    = CAL_TO_US * CLK_MHZ;
    localparam int LOCK_CYC   = LOCK_TO_US * CLK_MHZ;
    localparam int MAX_A      = (SETTLE_CYC > CAL_CYC) ? SETTLE_CYC : CAL_CYC;
    localparam int MAX_CYC    = (MAX_A > LOCK_CYC) ? MAX_A : LOCK_CYC;
    localparam int TW         = $clog2(MAX_CYC + 1) + 1;
    localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] CAL_LAST    = TW'(CAL_CYC - 1);
    localparam logic [TW-1:0] LOCK_LAST   = TW'(LOCK_CYC - 1);

    seq_state_e          state_q, state_d;
    logic                on_q;
    logic [RATE_W-1:0]   rate_q;
    logic [FREQ_W-1:0]   band;
    logic [TW-1:0]       cnt;
    logic [1:0]          stat_s;
    logic                cal_s, rdy_s, accept;

    emmc_sync2 #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({dll_rdy_i, cal_done_i}),
        .sync_o  (stat_s)
    );
    assign cal_s = stat_s[0];
    assign rdy_s = stat_s[1];

    emmc_rate_band #(.RATE_W(RATE_W)) u_band (
        .rate_i (rate_q),
        .band_o (band)
    );

    emmc_wait_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_d != state_q),
        .cnt   (cnt)
    );

    assign accept = (state_q == ST_IDLE) && req;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req) state_d = req_power_on ? ST_TXCLK : ST_PDB_LOW;
            ST_TXCLK:     state_d = ST_OTAP_EN;
            ST_OTAP_EN:   state_d = ST_OTAP_SEL;
            ST_OTAP_SEL:  state_d = ST_PDB_LOW;
            ST_PDB_LOW:   state_d = ST_DLL_LOW;
            ST_DLL_LOW:   state_d = on_q ? ST_SETTLE : ST_DONE;
            ST_SETTLE:    if (cnt == SETTLE_LAST) state_d = ST_PDB_HIGH;
            ST_PDB_HIGH:  state_d = ST_CAL_WAIT;
            ST_CAL_WAIT: begin
                if (cal_s)                 state_d = ST_SET_FREQ;
                else if (cnt == CAL_LAST)  state_d = ST_FAIL;
            end
            ST_SET_FREQ:  state_d = ST_DLL_ON;
            ST_DLL_ON:    state_d = (rate_q == '0) ? ST_DONE : ST_LOCK_WAIT;
            ST_LOCK_WAIT: begin
                if (rdy_s)                 state_d = ST_DONE;
                else if (cnt == LOCK_LAST) state_d = ST_FAIL;
            end
            ST_DONE:      state_d = ST_IDLE;
            ST_FAIL:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Output and request-capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_q          <= 1'b0;
            rate_q        <= '0;
            rate_warn     <= 1'b0;
            txclk_dly_sel <= 1'b0;
            otap_dly_en   <= 1'b0;
            otap_dly_sel  <= '0;
            pwr_dn_b      <= 1'b0;
            dll_en        <= 1'b0;
            dll_freq_sel  <= '0;
        end else begin
            if (accept) begin
                on_q      <= req_power_on;
                rate_q    <= rate_mhz;
                rate_warn <= req_power_on && (32'(rate_mhz) > 32'd175);
            end
            unique case (state_q)
                ST_TXCLK:    txclk_dly_sel <= 1'b1;
                ST_OTAP_EN:  otap_dly_en   <= 1'b1;
                ST_OTAP_SEL: otap_dly_sel  <= OTAP_SEL_VAL;
                ST_PDB_LOW:  pwr_dn_b      <= 1'b0;
                ST_DLL_LOW:  dll_en        <= 1'b0;
                ST_PDB_HIGH: pwr_dn_b      <= 1'b1;
                ST_SET_FREQ: dll_freq_sel  <= band;
                ST_DLL_ON:   dll_en        <= 1'b1;
                default: ;
            endcase
        end
    end

    assign busy  = (state_q != ST_IDLE);
    assign done  = (state_q == ST_DONE);
    assign error = (state_q == ST_FAIL);

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R12
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |=> !(done || error)); // R12
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !error) |=> busy); // R12
    AST_PDB_RISE_DLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_dn_b) |-> !dll_en); // R2
    AST_TAP_BEFORE_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_dn_b) |-> (txclk_dly_sel && otap_dly_en && otap_dly_sel == OTAP_SEL_VAL)); // R3
    AST_DLL_NEEDS_PDB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_en) |-> pwr_dn_b); // R8
    AST_FREQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_en) |-> $stable(dll_freq_sel)); // R8
    AST_WARN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rate_warn)); // R5
endmodule

// File: tb/emmc_phy_seq_test.sv
module emmc_phy_seq_test;
    localparam int CLK_MHZ = 2;
    localparam int SETTLE_CYC = 5 * CLK_MHZ;
    localparam int CAL_CYC = 50 * CLK_MHZ;
    localparam int LOCK_CYC = 300 * CLK_MHZ;

    logic clk = 0, rst_n = 0, req = 0, req_power_on = 0;
    logic [8:0] rate_mhz = '0;
    logic cal_done_i = 0, dll_rdy_i = 0;
    logic txclk_dly_sel, otap_dly_en, pwr_dn_b, dll_en, busy, done, error, rate_warn;
    logic [3:0] otap_dly_sel;
    logic [2:0] dll_freq_sel;

    int tests = 0, fails = 0;
    int cal_delay = 2, lock_delay = 3;
    bit cal_never = 0, lock_never = 0;
    int cal_cnt = 0, lock_cnt = 0;

    // timestamps of the current run (-1 = not seen)
    int t_tx, t_oe, t_os, t_pf, t_df, t_pr, t_dr, t_fq, t_end, f_at_dr;
    bit got_done, got_err, busy_at1, pulse_ok;

    always #2 clk = ~clk;

    emmc_phy_seq #(.CLK_MHZ(CLK_MHZ), .RATE_W(9), .SETTLE_US(5),
                   .CAL_TO_US(50), .LOCK_TO_US(300)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_power_on(req_power_on),
        .rate_mhz(rate_mhz), .cal_done_i(cal_done_i), .dll_rdy_i(dll_rdy_i),
        .txclk_dly_sel(txclk_dly_sel), .otap_dly_en(otap_dly_en),
        .otap_dly_sel(otap_dly_sel), .pwr_dn_b(pwr_dn_b), .dll_en(dll_en),
        .dll_freq_sel(dll_freq_sel), .busy(busy), .done(done), .error(error),
        .rate_warn(rate_warn));

    // PHY status model
    always @(posedge clk) begin
        cal_cnt    <= pwr_dn_b ? cal_cnt + 1 : 0;
        cal_done_i <= pwr_dn_b && !cal_never && (cal_cnt >= cal_delay);
        lock_cnt   <= dll_en ? lock_cnt + 1 : 0;
        dll_rdy_i  <= dll_en && !lock_never && (lock_cnt >= lock_delay);
    end

    function automatic int exp_band(input int r);
        if (r >= 170 && r <= 200) return 0;
        if (r >= 140 && r <= 170) return 1;
        if (r >= 110 && r <= 140) return 2;
        if (r >= 80 && r <= 110) return 3;
        if (r >= 50 && r <= 80) return 4;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic run(input bit on, input int rate, input bit inject);
        logic p_tx, p_oe, p_pdb, p_dll;
        logic [3:0] p_os;
        logic [2:0] p_fq;
        int cyc;
        t_tx = -1; t_oe = -1; t_os = -1; t_pf = -1; t_df = -1;
        t_pr = -1; t_dr = -1; t_fq = -1; t_end = -1; f_at_dr = -1;
        @(negedge clk);
        rate_mhz = 9'(rate); req_power_on = on; req = 1;
        p_tx = txclk_dly_sel; p_oe = otap_dly_en; p_os = otap_dly_sel;
        p_pdb = pwr_dn_b; p_dll = dll_en; p_fq = dll_freq_sel;
        @(negedge clk);
        req = 0; cyc = 1;
        busy_at1 = busy;
        while (cyc < 5000) begin
            if (!p_tx && txclk_dly_sel) t_tx = cyc;
            if (!p_oe && otap_dly_en) t_oe = cyc;
            if (p_os != 4'd2 && otap_dly_sel == 4'd2) t_os = cyc;
            if (p_pdb && !pwr_dn_b) t_pf = cyc;
            if (!p_pdb && pwr_dn_b) t_pr = cyc;
            if (p_dll && !dll_en) t_df = cyc;
            if (!p_dll && dll_en) begin t_dr = cyc; f_at_dr = dll_freq_sel; end
            if (p_fq != dll_freq_sel) t_fq = cyc;
            p_tx = txclk_dly_sel; p_oe = otap_dly_en; p_os = otap_dly_sel;
            p_pdb = pwr_dn_b; p_dll = dll_en; p_fq = dll_freq_sel;
            if (done || error) break;
            if (inject && cyc == 6) begin req = 1; req_power_on = !on; end
            @(negedge clk);
            req = 0;
            cyc++;
        end
        t_end = cyc; got_done = done; got_err = error;
        @(negedge clk);
        pulse_ok = !done && !error && !busy;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({txclk_dly_sel, otap_dly_en, otap_dly_sel, pwr_dn_b, dll_en, dll_freq_sel,
             busy, done, error, rate_warn} == '0, "R1 reset", 0, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !error, "R1 idle after reset", busy, 0);

        // R2 power-off from reset
        run(0, 100, 0);
        chk(got_done && !got_err, "R2 off done", got_done, 1);
        chk(t_tx == -1 && !txclk_dly_sel && otap_dly_sel == 0, "R2 off no tap change", t_tx, -1);
        chk(!pwr_dn_b && !dll_en, "R2 off controls low", {pwr_dn_b, dll_en}, 0);

        // R3/R11/R12 first power-on, calibration immediate
        cal_delay = 0;
        run(1, 100, 0);
        cal_delay = 2;
        chk(got_done, "R3 on done", got_done, 1);
        chk(t_tx > 0 && t_oe > t_tx && t_os > t_oe && t_pr > t_os, "R3 order tx<oe<os<pdb", t_os, t_oe + 1);
        chk(otap_dly_sel == 4'd2, "R3 otap sel", otap_dly_sel, 2);
        chk(t_dr - t_pr >= 5, "R11 sync latency", t_dr - t_pr, 5);
        chk(busy_at1, "R12 busy after accept", busy_at1, 1);
        chk(pulse_ok, "R12 done one cycle", pulse_ok, 1);
        chk(dll_en && pwr_dn_b, "R10 locked controls", {pwr_dn_b, dll_en}, 3);

        // R2/R6/R8 second power-on from powered state
        run(1, 150, 0);
        chk(t_pf > 0 && t_df > t_pf, "R2 pdb low before dll low", t_df, t_pf + 1);
        chk(t_pr - t_df >= SETTLE_CYC, "R6 settle", t_pr - t_df, SETTLE_CYC);
        chk(f_at_dr == 1 && t_fq > 0 && t_fq < t_dr, "R8 freq before dll", f_at_dr, 1);
        chk(t_dr > t_pr, "R8 dll after pdb", t_dr, t_pr + 1);

        // R2 power-off after power-on
        run(0, 0, 0);
        chk(got_done && !pwr_dn_b && !dll_en, "R2 off after on", {pwr_dn_b, dll_en}, 0);
        chk(txclk_dly_sel && otap_dly_en && otap_dly_sel == 2 && dll_freq_sel == 1,
            "R2 off keeps taps and freq", dll_freq_sel, 1);

        // R4/R5/R9 sweep over every rate
        for (int r = 0; r <= 260; r++) begin
            lock_never = (r == 0);
            run(1, r, 0);
            lock_never = 0;
            chk(got_done && !got_err, $sformatf("R5 done rate %0d", r), got_done, 1);
            chk(dll_freq_sel == 3'(exp_band(r)), $sformatf("R4 band rate %0d", r),
                dll_freq_sel, exp_band(r));
            chk(rate_warn == (r > 175), $sformatf("R5 warn rate %0d", r), rate_warn, r > 175);
            if (r == 0) chk(t_end - t_dr <= 1 && t_dr > 0, "R9 rate zero no lock wait", t_end - t_dr, 0);
        end

        // R5 warning cleared by power-off
        run(0, 0, 0);
        chk(!rate_warn, "R5 warn cleared by off", rate_warn, 0);

        // R7 calibration timeout
        cal_never = 1;
        run(1, 100, 0);
        cal_never = 0;
        chk(got_err && !got_done, "R7 cal timeout error", got_err, 1);
        chk(t_end - t_pr >= CAL_CYC && t_end - t_pr <= CAL_CYC + 4, "R7 cal timeout window",
            t_end - t_pr, CAL_CYC);
        chk(!dll_en, "R7 dll stays low", dll_en, 0);
        chk(pulse_ok, "R12 error one cycle", pulse_ok, 1);

        // R10 lock timeout
        lock_never = 1;
        run(1, 100, 0);
        lock_never = 0;
        chk(got_err, "R10 lock timeout error", got_err, 1);
        chk(t_end - t_dr >= LOCK_CYC && t_end - t_dr <= LOCK_CYC + 4, "R10 lock window",
            t_end - t_dr, LOCK_CYC);

        // R12 request during busy ignored
        run(1, 90, 1);
        chk(got_done && dll_en && pwr_dn_b, "R12 injected off ignored", dll_en, 1);
        repeat (4) @(negedge clk);
        chk(!busy && dll_en, "R12 no second sequence", busy, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule